// File: doc/BRIEF.md
# Iterative Bitsliced Block Encryption Core

This block encrypts one 128-bit block with a 32-round substitution-permutation cipher, doing one round per clock. The block is held as four 32-bit words. Each round takes a 4-bit substitution across all 32 bit positions of the words, then a fixed word-level mixing layer, then a subkey XOR. The 33 round subkeys are already expanded and live in a memory outside the block. The core addresses that memory with a subkey index and reads one 128-bit subkey each cycle, through a combinational read port.

A pulse on `start` while the core is idle captures the plaintext, the output mode and a destination block. The core then iterates for 32 cycles with `busy` high. It pulses `done` for one cycle with the result on `ct_out`. When `xor_en` was set at start, the result is XORed with the captured destination block before it goes out. This lets a caller fold the keystream or ciphertext into an existing buffer word without a second pass.

Top module: `serp_enc_core`

## Requirements
- R1: Word j (j = 0..3) of any 128-bit value on `pt_in`, `dst_in`, `sk_data` or `ct_out` is bits [32j+31:32j]. On an accepted start the working state becomes `pt_in` XOR subkey 0.
- R2: Round r (r = 0..31) applies S-box number r mod 8 to each bit position k. The input nibble is {w3[k],w2[k],w1[k],w0[k]}, with w0 as bit 0, and output bit j goes to word j. Each table is listed from input 0 to 15 in hex:
  - S0 = 3,8,F,1,A,6,5,B,E,D,4,2,7,0,9,C
  - S1 = F,C,2,7,9,0,5,A,1,B,E,8,6,D,3,4
  - S2 = 8,6,7,9,3,C,A,F,D,1,E,4,0,B,5,2
  - S3 = 0,F,B,8,C,9,6,3,D,1,2,4,A,7,5,E
  - S4 = 1,F,8,3,C,0,B,6,2,5,4,A,9,E,7,D
  - S5 = F,5,2,B,4,A,9,C,0,3,E,8,D,6,7,1
  - S6 = 7,2,C,5,8,4,6,B,E,9,1,F,D,3,A,0
  - S7 = 1,D,F,0,E,8,2,B,7,4,C,9,3,5,A,6
- R3: In rounds 0..30 the substitution is followed by the mixing layer and then an XOR with subkey r+1. The mixing layer runs these steps in order, with `<<` a logical shift:
  - a = rotl(w0,13), c = rotl(w2,3)
  - b = w1^a^c, d = w3^c^(a<<3)
  - b = rotl(b,1), d = rotl(d,7)
  - a ^= b^d, c ^= d^(b<<7)
  - a = rotl(a,5), c = rotl(c,22)
- R4: Round 31 skips the mixing layer and XORs subkey 32 directly after the substitution.
- R5: `sk_idx` is 0 while idle and r+1 during round r. Word j of the subkey read is `sk_data` bits [32j+31:32j].
- R6: `busy` is high for exactly 32 cycles after the start edge. `done` is high for exactly one cycle, the cycle after the last round.
- R7: With `xor_en` high at start, `ct_out` is the cipher result XOR the `dst_in` value captured at start. With it low, `ct_out` is the plain result. Changes to `dst_in` or `xor_en` after start have no effect.
- R8: `start` and changes of `pt_in` while `busy` is high are ignored: the result of the block in flight is unchanged.
- R9: After reset, `busy`, `done`, `ct_out` and `sk_idx` are all zero.
- R10: `ct_out` holds its value until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a block (accepted only when idle) |
| xor_en | input | 1 | Output mode: 1 = XOR result into destination block |
| pt_in | input | 128 | Plaintext block |
| dst_in | input | 128 | Destination block for XOR mode |
| sk_idx | output | 6 | Subkey index to the external subkey memory |
| sk_data | input | 128 | Subkey read back for `sk_idx` |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle result strobe |
| ct_out | output | 128 | Result block |

## Verification
The core is run against an arithmetic model with several kinds of input:
- **All-zero and all-ones plaintext and subkeys.** These mostly expose S-box table entries at the extremes.
- **A single walking bit in the plaintext or in one subkey.** This separates the word and bit ordering and the direction of each rotate and shift in the mixing layer.
- **Pseudo-random blocks.** These exercise all eight tables over many nibbles.

The subkey index is compared with the round count on every cycle. XOR-mode runs change `dst_in` mid-flight to show it was captured at start. Other runs raise `start` and change `pt_in` mid-flight to show they are ignored.

// File: rtl/serp_pkg.sv
package serp_pkg;
    localparam int WORD_W  = 32;
    localparam int N_WORDS = 4;
    localparam int BLK_W   = WORD_W * N_WORDS;
    localparam int N_SBOX  = 8;

    typedef logic [N_WORDS-1:0][WORD_W-1:0] blk_t;

    // nibble i of each constant is the table output for input i
    localparam logic [N_SBOX-1:0][63:0] SBOX_PACK = {
        64'h6A539C47B28E0FD1,
        64'h0A3DF19EB6485C27,
        64'h176D8E30C9A4B25F,
        64'hD7E9A4526B0C38F1,
        64'hE57A421D369C8BF0,
        64'h25B04E1DFAC39768,
        64'h43D68EB1A50972CF,
        64'hC90724DEB56A1F83
    };

    localparam int ROT_A0 = 13;
    localparam int ROT_C0 = 3;
    localparam int SHL_D  = 3;
    localparam int ROT_B1 = 1;
    localparam int ROT_D1 = 7;
    localparam int SHL_C  = 7;
    localparam int ROT_A2 = 5;
    localparam int ROT_C2 = 22;

    function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] v, input int n);
        return (v << n) | (v >> (WORD_W - n));
    endfunction
endpackage

// File: rtl/serp_sbox_layer.sv
module serp_sbox_layer
    import serp_pkg::*;
(
    input  blk_t       din,
    input  logic [2:0] sel,
    output blk_t       dout
);
    logic [63:0] table_sel;
    assign table_sel = SBOX_PACK[sel];

    for (genvar k = 0; k < WORD_W; k++) begin : g_lane
        logic [3:0] nib_in;
        logic [3:0] nib_out;
        assign nib_in  = {din[3][k], din[2][k], din[1][k], din[0][k]};
        assign nib_out = table_sel[{nib_in, 2'b00} +: 4];
        for (genvar j = 0; j < N_WORDS; j++) begin : g_word
            assign dout[j][k] = nib_out[j];
        end
    end
endmodule

// File: rtl/serp_mix_layer.sv
module serp_mix_layer
    import serp_pkg::*;
(
    input  blk_t din,
    output blk_t dout
);
    logic [WORD_W-1:0] a0, c0, b0, d0, b1, d1, a1, c1;

    always_comb begin
        a0 = rotl(din[0], ROT_A0);
        c0 = rotl(din[2], ROT_C0);
        b0 = din[1] ^ a0 ^ c0;
        d0 = din[3] ^ c0 ^ (a0 << SHL_D);
        b1 = rotl(b0, ROT_B1);
        d1 = rotl(d0, ROT_D1);
        a1 = a0 ^ b1 ^ d1;
        c1 = c0 ^ d1 ^ (b1 << SHL_C);
        dout[0] = rotl(a1, ROT_A2);
        dout[1] = b1;
        dout[2] = rotl(c1, ROT_C2);
        dout[3] = d1;
    end
endmodule

// File: rtl/serp_enc_core.sv
module serp_enc_core
    import serp_pkg::*;
#(
    parameter int ROUNDS = 32,
    localparam int RW    = $clog2(ROUNDS),
    localparam int SKW   = $clog2(ROUNDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             xor_en,
    input  logic [BLK_W-1:0] pt_in,
    input  logic [BLK_W-1:0] dst_in,
    output logic [SKW-1:0]   sk_idx,
    input  logic [BLK_W-1:0] sk_data,
    output logic             busy,
    output logic             done,
    output logic [BLK_W-1:0] ct_out
);
    typedef struct packed {
        logic          busy;
        logic          done;
        logic          xmode;
        logic [RW-1:0] round;
        blk_t          st;
        blk_t          dst;
        blk_t          res;
    } core_t;

    core_t q, d;
    blk_t  sub_out, mix_out, pre_key, keyed;
    logic  last_round;

    // round index mod 8 picks the table (ROUNDS is at least 8)
    serp_sbox_layer u_sbox (
        .din  (q.st),
        .sel  (q.round[2:0]),
        .dout (sub_out)
    );

    serp_mix_layer u_mix (
        .din  (sub_out),
        .dout (mix_out)
    );

    assign last_round = (q.round == RW'(ROUNDS - 1));
    assign pre_key    = last_round ? sub_out : mix_out;
    assign keyed      = pre_key ^ blk_t'(sk_data);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        sk_idx = q.busy ? (SKW'(q.round) + SKW'(1)) : '0;
        if (!q.busy) begin
            if (start) begin
                d.busy  = 1'b1;
                d.round = '0;
                d.st    = blk_t'(pt_in) ^ blk_t'(sk_data);
                d.xmode = xor_en;
                d.dst   = blk_t'(dst_in);
            end
        end else begin
            d.st = keyed;
            if (last_round) begin
                d.busy = 1'b0;
                d.done = 1'b1;
                d.res  = q.xmode ? (keyed ^ q.dst) : keyed;
            end else begin
                d.round = q.round + RW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy   = q.busy;
    assign done   = q.done;
    assign ct_out = q.res;

    // R5: idle index is zero
    assert_idle_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sk_idx == '0);

    // R5: index advances by one per round while iterating
    assert_index_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sk_idx != SKW'(ROUNDS)) |=> (busy && sk_idx == $past(sk_idx) + SKW'(1)));

    // R6: done follows the final round only, and never overlaps busy
    assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sk_idx == SKW'(ROUNDS)) |=> (done && !busy));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: a start while busy does not restart the index
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && sk_idx > SKW'(1) && sk_idx != SKW'(ROUNDS)) |=> sk_idx > SKW'(2));

    // R10: result changes only with done
    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(ct_out));
endmodule

// File: tb/sim_serp_enc_core.sv
module sim_serp_enc_core;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         xor_en = 1'b0;
    logic [127:0] pt_in = '0;
    logic [127:0] dst_in = '0;
    logic [5:0]   sk_idx;
    logic [127:0] sk_data;
    logic         busy, done;
    logic [127:0] ct_out;

    logic [127:0] skm [0:32];
    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [63:0] lcg = 64'h2545F4914F6CDD1D;

    always #4 clk = ~clk;

    assign sk_data = (sk_idx <= 6'd32) ? skm[sk_idx] : '0;

    serp_enc_core u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .xor_en(xor_en),
        .pt_in(pt_in), .dst_in(dst_in), .sk_idx(sk_idx), .sk_data(sk_data),
        .busy(busy), .done(done), .ct_out(ct_out)
    );

    localparam logic [3:0] T0 [16] = '{4'h3,4'h8,4'hF,4'h1,4'hA,4'h6,4'h5,4'hB,4'hE,4'hD,4'h4,4'h2,4'h7,4'h0,4'h9,4'hC};
    localparam logic [3:0] T1 [16] = '{4'hF,4'hC,4'h2,4'h7,4'h9,4'h0,4'h5,4'hA,4'h1,4'hB,4'hE,4'h8,4'h6,4'hD,4'h3,4'h4};
    localparam logic [3:0] T2 [16] = '{4'h8,4'h6,4'h7,4'h9,4'h3,4'hC,4'hA,4'hF,4'hD,4'h1,4'hE,4'h4,4'h0,4'hB,4'h5,4'h2};
    localparam logic [3:0] T3 [16] = '{4'h0,4'hF,4'hB,4'h8,4'hC,4'h9,4'h6,4'h3,4'hD,4'h1,4'h2,4'h4,4'hA,4'h7,4'h5,4'hE};
    localparam logic [3:0] T4 [16] = '{4'h1,4'hF,4'h8,4'h3,4'hC,4'h0,4'hB,4'h6,4'h2,4'h5,4'h4,4'hA,4'h9,4'hE,4'h7,4'hD};
    localparam logic [3:0] T5 [16] = '{4'hF,4'h5,4'h2,4'hB,4'h4,4'hA,4'h9,4'hC,4'h0,4'h3,4'hE,4'h8,4'hD,4'h6,4'h7,4'h1};
    localparam logic [3:0] T6 [16] = '{4'h7,4'h2,4'hC,4'h5,4'h8,4'h4,4'h6,4'hB,4'hE,4'h9,4'h1,4'hF,4'hD,4'h3,4'hA,4'h0};
    localparam logic [3:0] T7 [16] = '{4'h1,4'hD,4'hF,4'h0,4'hE,4'h8,4'h2,4'hB,4'h7,4'h4,4'hC,4'h9,4'h3,4'h5,4'hA,4'h6};

    function automatic logic [3:0] tab(input int s, input logic [3:0] n);
        case (s)
            0: return T0[n];
            1: return T1[n];
            2: return T2[n];
            3: return T3[n];
            4: return T4[n];
            5: return T5[n];
            6: return T6[n];
            default: return T7[n];
        endcase
    endfunction

    function automatic logic [31:0] rl(input logic [31:0] v, input int n);
        logic [31:0] r = v;
        for (int i = 0; i < n; i++) r = {r[30:0], r[31]};
        return r;
    endfunction

    // arithmetic model of R1..R4
    function automatic logic [127:0] model(input logic [127:0] pt);
        logic [31:0] w [4];
        logic [31:0] nw [4];
        logic [3:0]  nb, o;
        logic [31:0] a, b, c, e;
        for (int j = 0; j < 4; j++) w[j] = pt[32*j +: 32] ^ skm[0][32*j +: 32];
        for (int r = 0; r < 32; r++) begin
            for (int k = 0; k < 32; k++) begin
                nb = {w[3][k], w[2][k], w[1][k], w[0][k]};
                o  = tab(r % 8, nb);
                for (int j = 0; j < 4; j++) nw[j][k] = o[j];
            end
            if (r < 31) begin
                a = rl(nw[0], 13); c = rl(nw[2], 3);
                b = nw[1] ^ a ^ c; e = nw[3] ^ c ^ (a << 3);
                b = rl(b, 1); e = rl(e, 7);
                a = a ^ b ^ e; c = c ^ e ^ (b << 7);
                nw[0] = rl(a, 5); nw[1] = b; nw[2] = rl(c, 22); nw[3] = e;
            end
            for (int j = 0; j < 4; j++) w[j] = nw[j] ^ skm[r+1][32*j +: 32];
        end
        return {w[3], w[2], w[1], w[0]};
    endfunction

    function automatic logic [127:0] rnd128();
        logic [127:0] v;
        for (int i = 0; i < 4; i++) begin
            lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
            v[32*i +: 32] = lcg[63:32];
        end
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic keys_fill(input int kind);
        for (int i = 0; i <= 32; i++) begin
            case (kind)
                0: skm[i] = '0;
                1: skm[i] = '1;
                default: skm[i] = rnd128();
            endcase
        end
    endtask

    // interfere: 0 none, 1 start+pt change mid-flight, 2 dst/xor change mid-flight
    task automatic run_block(input logic [127:0] pt, input logic [127:0] dst,
                             input bit xm, input int interfere);
        logic [127:0] exp;
        exp = model(pt);
        if (xm) exp = exp ^ dst;
        @(negedge clk);
        pt_in = pt; dst_in = dst; xor_en = xm; start = 1'b1;
        for (int n = 1; n <= 32; n++) begin
            @(negedge clk);
            start = 1'b0;
            chk(busy === 1'b1 && done === 1'b0, "R6 busy during rounds", {127'd0, busy}, 128'd1);
            chk(sk_idx === 6'(n), "R5 subkey index", {122'd0, sk_idx}, 128'(n));
            if (interfere == 1 && n == 5) begin
                start = 1'b1; pt_in = ~pt;
            end
            if (interfere == 1 && n == 6) pt_in = rnd128();
            if (interfere == 2 && n == 3) begin
                dst_in = ~dst; xor_en = ~xm;
            end
        end
        @(negedge clk);
        start = 1'b0;
        chk(done === 1'b1 && busy === 1'b0, "R6 done after 32 rounds", {126'd0, busy, done}, 128'd1);
        chk(ct_out === exp, interfere == 1 ? "R8 mid-flight start ignored" :
                            (xm ? "R7 xor into destination" : "R1 R2 R3 R4 cipher result"),
            ct_out, exp);
        @(negedge clk);
        chk(done === 1'b0, "R6 done one cycle", {127'd0, done}, 128'd0);
        chk(sk_idx === 6'd0, "R5 idle index", {122'd0, sk_idx}, 128'd0);
        chk(ct_out === exp, "R10 result held", ct_out, exp);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [127:0] v;
        keys_fill(0);
        #1;
        chk(busy === 1'b0 && done === 1'b0, "R9 reset flags", {126'd0, busy, done}, 128'd0);
        chk(ct_out === '0, "R9 reset result", ct_out, 128'd0);
        chk(sk_idx === 6'd0, "R9 reset index", {122'd0, sk_idx}, 128'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // zero and all-ones patterns
        keys_fill(0); run_block('0, '0, 1'b0, 0);
        run_block('1, '0, 1'b0, 0);
        keys_fill(1); run_block('0, '0, 1'b0, 0);
        run_block('1, '0, 1'b0, 0);

        // walking bit in plaintext
        keys_fill(0);
        for (int p = 0; p < 128; p += 19) begin
            v = '0; v[p] = 1'b1;
            run_block(v, '0, 1'b0, 0);
        end
        // walking bit in single subkeys (incl. first and last)
        for (int i = 0; i <= 32; i += 8) begin
            keys_fill(0);
            skm[i][(i * 5) % 128] = 1'b1;
            run_block('0, '0, 1'b0, 0);
        end

        // random blocks
        for (int t = 0; t < 20; t++) begin
            keys_fill(2);
            run_block(rnd128(), '0, 1'b0, 0);
        end

        // xor mode, including destination change mid-flight (R7)
        for (int t = 0; t < 4; t++) begin
            keys_fill(2);
            run_block(rnd128(), rnd128(), 1'b1, t % 2 == 0 ? 0 : 2);
        end
        keys_fill(2);
        run_block(rnd128(), rnd128(), 1'b0, 2);

        // start and plaintext changes while busy (R8)
        for (int t = 0; t < 3; t++) begin
            keys_fill(2);
            run_block(rnd128(), '0, 1'b0, 1);
        end

        // hold with changing inputs and no start (R10)
        v = ct_out;
        for (int t = 0; t < 4; t++) begin
            @(negedge clk);
            pt_in = rnd128(); dst_in = rnd128();
            chk(ct_out === v && busy === 1'b0, "R10 idle hold", ct_out, v);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule